// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the array address for a pipelined synchronous burst SRAM. A new external address is captured when one of two active-low strobes is sampled low at a rising clock edge. One strobe belongs to the cache controller and always loads. The other belongs to the processor and loads only while the master chip enable is active. The captured address becomes the first beat of a four-beat burst. Each later edge that sees the active-low advance input low moves the burst on by one beat. While advance stays high, the burst waits on its current beat.

Only the two least-significant address bits move during a burst. A select pin picks the beat order. When it is high the order is interleaved: the start bits XOR a beat count of 0, 1, 2, 3. When it is low the order is linear: the start bits plus the beat count, modulo 4. After the fourth beat the sequence wraps back to the start. The upper bits keep their captured value until the next load. The order pin acts on the output directly, so the current beat can be shown in either order without reloading. There is no data flow through the block, so all pins are plain control and address signals.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the address register and the beat count both clear. After reset `cur_addr` reads 0.
- R2: `ctl_ads_n` low at an edge loads `ext_addr` and resets the beat count to 0, whatever the level of `mst_en`. On the next cycle `cur_addr` equals the loaded address in either order.
- R3: `cpu_ads_n` low with `mst_en` high at an edge loads `ext_addr` and resets the beat count to 0.
- R4: `cpu_ads_n` low with `mst_en` low and `ctl_ads_n` high loads nothing. The upper bits stay unchanged, and the edge is treated like a no-strobe edge that obeys `adv_n`.
- R5: On an edge with no load and `adv_n` low, the beat count (0..3) increases by one, modulo 4.
- R6: On an edge with no load and `adv_n` high, the burst is suspended and `cur_addr` is unchanged.
- R7: With `ilv_sel` = 0 (linear order), `cur_addr[1:0]` = (start[1:0] + beat) mod 4. The fifth beat equals the first.
- R8: With `ilv_sel` = 1 (interleaved order), `cur_addr[1:0]` = start[1:0] XOR beat.
- R9: `cur_addr[AW-1:2]` equals the upper bits of the last loaded address on every cycle until the next load.
- R10: When both strobes load on the same edge, a new burst starts at beat 0 and `adv_n` is ignored on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | AW | External address to load |
| ctl_ads_n | input | 1 | Controller address strobe, active low, never gated |
| cpu_ads_n | input | 1 | Processor address strobe, active low, gated by mst_en |
| mst_en | input | 1 | Master chip enable, active high, gates cpu_ads_n only |
| adv_n | input | 1 | Advance to next beat, active low |
| ilv_sel | input | 1 | Beat order: 1 interleaved, 0 linear |
| cur_addr | output | AW | Current array address |

## Verification
A wrong beat count appears in `cur_addr[1:0]` in the very cycle after the faulty edge. In interleaved order and in linear order the same count maps to different low bits, so sweeping both orders and all four start values separates a bad count from a bad mapping. A wrongly gated or missed load appears one cycle later as upper bits that do not match the expected address, or as a low-bit value that did not restart. A suspend that leaks an advance shifts every later beat by one, so checking each beat through a full wrap shows the fault right away.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} order_e;
endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl (
  input  logic ctl_ads_n,
  input  logic cpu_ads_n,
  input  logic mst_en,
  input  logic adv_n,
  output logic load,
  output logic step
);
  // The controller strobe is never gated. The processor strobe needs the master enable.
  always_comb begin
    load = !ctl_ads_n || (!cpu_ads_n && mst_en);
    step = !load && !adv_n;
  end
endmodule

// File: rtl/beat_counter.sv
module beat_counter
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  step,
  output beat_t beat
);
  always_ff @(posedge clk) begin
    if (rst)       beat <= '0;
    else if (load) beat <= '0;
    else if (step) beat <= beat + beat_t'(1);
  end

  // R5
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && step) |=> beat == beat_t'($past(beat) + beat_t'(1)));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(beat));
  // R10
  load_restart_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> beat == '0);
endmodule

// File: rtl/order_map.sv
module order_map
  import burst_seq_pkg::*;
(
  input  beat_t  start,
  input  beat_t  beat,
  input  order_e order,
  output beat_t  low
);
  beat_t lin_low, ilv_low;
  always_comb begin
    lin_low = start + beat;
    ilv_low = start ^ beat;
    low = (order == ORD_INTERLEAVE) ? ilv_low : lin_low;
  end

  // R8
  always_comb begin
    ilv_zero_chk: assert (!(order == ORD_INTERLEAVE && beat == '0) || low == start);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ext_addr,
  input  logic          ctl_ads_n,
  input  logic          cpu_ads_n,
  input  logic          mst_en,
  input  logic          adv_n,
  input  logic          ilv_sel,
  output logic [AW-1:0] cur_addr
);
  localparam int UP_W = AW - BEAT_W;

  logic          load, step;
  beat_t         beat, low;
  logic [AW-1:0] base_q;
  order_e        order;

  burst_load_ctl u_ctl (
    .ctl_ads_n(ctl_ads_n), .cpu_ads_n(cpu_ads_n), .mst_en(mst_en),
    .adv_n(adv_n), .load(load), .step(step)
  );

  beat_counter u_cnt (
    .clk(clk), .rst(rst), .load(load), .step(step), .beat(beat)
  );

  always_ff @(posedge clk) begin
    if (rst)       base_q <= '0;
    else if (load) base_q <= ext_addr;
  end

  assign order = ilv_sel ? ORD_INTERLEAVE : ORD_LINEAR;

  order_map u_map (
    .start(base_q[BEAT_W-1:0]), .beat(beat), .order(order), .low(low)
  );

  assign cur_addr = {base_q[AW-1:BEAT_W], low};

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_ads_n |=> cur_addr == $past(ext_addr));
  // R3
  cpu_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_ads_n && mst_en) |=> cur_addr == $past(ext_addr));
  // R4
  gated_cpu_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_ads_n && !mst_en && ctl_ads_n) |=> $stable(cur_addr[AW-1:BEAT_W]));
  // R9
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_ads_n && (cpu_ads_n || !mst_en)) |=> $stable(cur_addr[AW-1:AW-UP_W]));
  // R6
  suspend_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_ads_n && (cpu_ads_n || !mst_en) && adv_n && $stable(ilv_sel)) |=> $stable(cur_addr));
  // R1
  reset_chk: assert property (@(posedge clk) rst |=> cur_addr == '0);
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 19;

  logic          clk = 0;
  logic          rst;
  logic [AW-1:0] ext_addr;
  logic          ctl_ads_n, cpu_ads_n, mst_en, adv_n, ilv_sel;
  logic [AW-1:0] cur_addr;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] m_base;
  int m_beat;

  always #5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u_burst_addr_seq (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .ctl_ads_n(ctl_ads_n),
    .cpu_ads_n(cpu_ads_n), .mst_en(mst_en), .adv_n(adv_n),
    .ilv_sel(ilv_sel), .cur_addr(cur_addr)
  );

  function automatic logic [AW-1:0] model_addr(logic [AW-1:0] b, int bt, logic ilv);
    logic [1:0] lo;
    if (ilv) lo = b[1:0] ^ 2'(bt);
    else     lo = 2'((int'(b[1:0]) + bt) % 4);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(string tag, logic [AW-1:0] got, logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Apply inputs, take one edge, update the model, sample 2 ns after the edge.
  task automatic tick(logic c_n, logic p_n, logic en, logic a_n, logic [AW-1:0] a);
    ctl_ads_n = c_n; cpu_ads_n = p_n; mst_en = en; adv_n = a_n; ext_addr = a;
    @(posedge clk);
    if (!c_n || (!p_n && en)) begin m_base = a; m_beat = 0; end
    else if (!a_n) m_beat = (m_beat + 1) % 4;
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; ext_addr = '1; ctl_ads_n = 1; cpu_ads_n = 1; mst_en = 0; adv_n = 1; ilv_sel = 1;
    @(posedge clk); @(posedge clk); #2;
    check("R1 reset", cur_addr, '0);
    rst = 0; m_base = '0; m_beat = 0;

    // Sweep both orders, all start bits and all three loading paths through a full wrap.
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        for (int path = 0; path < 3; path++) begin
          logic [AW-1:0] a;
          a = {17'(32'h0ACE5 * (s + 1) + path * 7 + o * 3), 2'(s)};
          ilv_sel = logic'(o);
          if (path == 0)      tick(0, 1, 0, 0, a);   // controller strobe, gated enable low
          else if (path == 1) tick(1, 0, 1, 1, a);   // processor strobe, enabled
          else                tick(0, 0, 1, 0, a);   // both strobes, advance low
          if (path == 0)      check("R2 ctl load", cur_addr, a);
          else if (path == 1) check("R3 cpu load", cur_addr, a);
          else                check("R10 both strobes", cur_addr, a);
          for (int k = 1; k <= 5; k++) begin
            tick(1, 1, 1, 0, '0);
            check(o ? "R8 interleave beat" : "R7 linear beat", cur_addr, model_addr(m_base, m_beat, o[0]));
            check("R9 upper hold", cur_addr, model_addr(m_base, m_beat, o[0]));
          end
          // Suspend two cycles.
          for (int k = 0; k < 2; k++) begin
            tick(1, 1, 1, 1, '1);
            check("R6 suspend", cur_addr, model_addr(m_base, m_beat, o[0]));
          end
          // Gated processor strobe, with and without advance.
          tick(1, 0, 0, 1, ~a);
          check("R4 gated cpu hold", cur_addr, model_addr(m_base, m_beat, o[0]));
          tick(1, 0, 0, 0, ~a);
          check("R4 gated cpu advance", cur_addr, model_addr(m_base, m_beat, o[0]));
          check("R5 step", cur_addr[1:0], model_addr(m_base, m_beat, o[0]) & 2'h3);
        end
      end
    end

    // Order pin switches the mapping of the current beat immediately.
    ilv_sel = 0;
    tick(0, 1, 1, 1, 19'h12341);
    tick(1, 1, 1, 0, '0);
    tick(1, 1, 1, 0, '0);
    check("R7 linear start1 beat2", cur_addr, 19'h12343);
    ilv_sel = 1; #1;
    check("R8 interleave start1 beat2", cur_addr, 19'h12343 ^ 19'h0 & 19'h7FFFC | 19'h3);

    rst = 1; @(posedge clk); #2; rst = 0;
    check("R1 reset after use", cur_addr, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule